// File: doc/BRIEF.md
# Left Shift Register with Parallel Load

This block is an N-bit register that can be cleared, loaded in parallel, or shifted left by one place. A clear is applied at once through an active-low asynchronous input and overrides everything else. On each rising clock edge while the clear is released, the register does exactly one of three things. A load request copies the parallel input. Otherwise, a shift request moves every bit one place toward the most significant end. With neither request, the register holds.

During a shift, the serial input bit fills the least significant position and the old most significant bit is lost. The block suits serial-to-parallel capture, where a parallel preset is sometimes needed before the bits stream in. The register contents appear directly on the parallel output.

Top module: `shl_load_reg`

## Requirements
- R1: While rst_ni is 0, q_o becomes all zeros at once, without waiting for a clock edge, whatever load_i and shift_i are.
- R2: On a rising clk_i edge with rst_ni = 1 and load_i = 1, q_o takes the value of par_i. The value of shift_i has no effect.
- R3: On a rising clk_i edge with rst_ni = 1, load_i = 0 and shift_i = 1, every bit q_o[i] takes the old q_o[i-1] for i from 1 to N-1.
- R4: During a shift, q_o[0] takes the value of ser_i sampled at that edge.
- R5: During a shift, the old q_o[N-1] is discarded. After N shifts, q_o holds only the last N serial bits.
- R6: On a rising clk_i edge with rst_ni = 1, load_i = 0 and shift_i = 0, q_o keeps its value. Changes on par_i and ser_i have no effect.
- R7: While rst_ni stays 0 across clock edges, q_o stays all zeros even with load_i or shift_i set to 1.
- R8: The width is set by parameter N (at least 2, default 8), and it applies to par_i and q_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the register updates on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous clear |
| load_i | input | 1 | Parallel load request; takes priority over shift |
| shift_i | input | 1 | Left shift request |
| ser_i | input | 1 | Serial bit that enters bit 0 during a shift |
| par_i | input | N | Parallel load data |
| q_o | output | N | Register contents |

## Verification
The bench checks the priority rules in several ways:
- A few distinct loaded values, including all ones and a checkerboard, show whether each bit position is captured on its own.
- A single one walked across all N positions shows misrouted or dropped bits and the discard of the top bit.
- Alternating serial bits and streams of all ones are shifted in, which tells the serial entry apart from a zero fill.
- Cycles with load and shift both requested separate load priority from shift priority.
- Hold cycles with changing parallel and serial inputs expose any leak into the register.
- A clear applied in mid-cycle, with both requests set, shows that the clear acts at once and does not wait for the clock.

// File: rtl/shl_load_pkg.sv
package shl_load_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } shl_op_e;
endpackage

// File: rtl/shl_load_ctrl.sv
module shl_load_ctrl
  import shl_load_pkg::*;
(
  input  logic    load_i,
  input  logic    shift_i,
  output shl_op_e op_o
);
  // load outranks shift (R2)
  always_comb begin
    if (load_i)       op_o = OP_LOAD;
    else if (shift_i) op_o = OP_SHIFT;
    else              op_o = OP_HOLD;
  end
endmodule

// File: rtl/shl_load_slice.sv
module shl_load_slice
  import shl_load_pkg::*;
(
  input  shl_op_e op_i,
  input  logic    cur_i,
  input  logic    par_i,
  input  logic    low_i,
  output logic    nxt_o
);
  always_comb begin
    unique case (op_i)
      OP_LOAD:  nxt_o = par_i;
      OP_SHIFT: nxt_o = low_i;
      default:  nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/shl_load_reg.sv
module shl_load_reg
  import shl_load_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic         ser_i,
  input  logic [N-1:0] par_i,
  output logic [N-1:0] q_o
);
  localparam int unsigned MSB = N - 1;

  shl_op_e      op;
  logic [MSB:0] q_q;
  logic [MSB:0] q_d;

  shl_load_ctrl u_ctrl (
    .load_i  (load_i),
    .shift_i (shift_i),
    .op_o    (op)
  );

  for (genvar i = 0; i < N; i++) begin : g_slice
    logic low;
    if (i == 0) begin : g_lsb
      assign low = ser_i;
    end else begin : g_upper
      assign low = q_q[i-1];
    end
    shl_load_slice u_slice (
      .op_i  (op),
      .cur_i (q_q[i]),
      .par_i (par_i[i]),
      .low_i (low),
      .nxt_o (q_d[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/shl_load_chk.sv
module shl_load_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         load_i,
  input logic         shift_i,
  input logic         ser_i,
  input logic [N-1:0] par_i,
  input logic [N-1:0] q_o
);
  // R7
  clear_holds_chk: assert property (@(posedge clk_i)
    !rst_ni |-> q_o == '0);

  // R2
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(par_i));

  // R3 R4 R5
  shift_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && shift_i) |=> q_o == N'({$past(q_o), $past(ser_i)}));

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(q_o));

  // R8
  initial begin
    width_ok_chk: assert (N >= 2);
  end
endmodule

bind shl_load_reg shl_load_chk #(.N(N)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .load_i  (load_i),
  .shift_i (shift_i),
  .ser_i   (ser_i),
  .par_i   (par_i),
  .q_o     (q_o)
);

// File: tb/tb_shl_load_reg.sv
`timescale 1ns/1ps
module tb_shl_load_reg;
  localparam int unsigned N = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         load_i = 1'b0;
  logic         shift_i = 1'b0;
  logic         ser_i = 1'b0;
  logic [N-1:0] par_i = '0;
  logic [N-1:0] q_o;

  int vectors = 0;
  int errors  = 0;
  logic [N-1:0] model = '0;

  always #2.5 clk_i = ~clk_i;

  shl_load_reg #(.N(N)) dut (
    .clk_i, .rst_ni, .load_i, .shift_i, .ser_i, .par_i, .q_o
  );

  task automatic check(input string req, input logic [N-1:0] exp);
    vectors++;
    if (q_o !== exp) begin
      errors++;
      $display("FAIL %s: q_o=%h expected=%h", req, q_o, exp);
    end
  endtask

  // drive at negedge, clock once, compare at next negedge
  task automatic step(input string req, input logic ld, input logic sh,
                      input logic sr, input logic [N-1:0] pd);
    load_i = ld; shift_i = sh; ser_i = sr; par_i = pd;
    if (ld)      model = pd;
    else if (sh) model = (model << 1) | N'(sr);
    @(posedge clk_i);
    @(negedge clk_i);
    check(req, model);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: q_o=%h expected=done", q_o);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    load_i = 1'b1; shift_i = 1'b1; par_i = '1;
    repeat (3) @(negedge clk_i);
    check("R7 clear held over edges", '0);
    rst_ni = 1'b1;
    load_i = 1'b0; shift_i = 1'b0;
    @(negedge clk_i);
    check("R1 reset state", '0);

    // R2 loads, with shift also requested on some
    step("R2 load a5", 1'b1, 1'b0, 1'b0, 8'hA5);
    step("R2 load over shift", 1'b1, 1'b1, 1'b1, 8'h3C);
    step("R2 load all ones", 1'b1, 1'b1, 1'b0, 8'hFF);
    step("R2 load zero", 1'b1, 1'b0, 1'b1, 8'h00);

    // R6 hold with noisy inputs
    step("R2 load 5a", 1'b1, 1'b0, 1'b0, 8'h5A);
    for (int k = 0; k < 4; k++)
      step("R6 hold", 1'b0, 1'b0, k[0], 8'(k * 37 + 1));

    // R3 R5 walking one
    step("R2 load one", 1'b1, 1'b0, 1'b0, 8'h01);
    for (int k = 0; k < N; k++)
      step("R3 R5 walk", 1'b0, 1'b1, 1'b0, 8'hFF);
    check("R5 msb discarded", '0);

    // R4 alternating serial bits
    for (int k = 0; k < N; k++)
      step("R4 serial alt", 1'b0, 1'b1, k[0], 8'h00);
    check("R4 alternating pattern", 8'h55);

    // R4 R5 flush with ones then zeros
    for (int k = 0; k < N; k++)
      step("R4 serial ones", 1'b0, 1'b1, 1'b1, 8'h00);
    check("R5 full flush ones", '1);
    step("R3 one zero in", 1'b0, 1'b1, 1'b0, 8'h00);
    check("R3 shifted", 8'hFE);

    // R1 mid-cycle clear with both requests active
    step("R2 load c3", 1'b1, 1'b0, 1'b0, 8'hC3);
    load_i = 1'b1; shift_i = 1'b1; par_i = 8'hFF;
    #1 rst_ni = 1'b0;
    #0.5;
    check("R1 async clear", '0);
    @(negedge clk_i);
    check("R7 clear over load", '0);
    #0.5 rst_ni = 1'b1;
    model = '0;
    load_i = 1'b0; shift_i = 1'b0;
    @(negedge clk_i);
    check("R6 hold after clear", '0);
    step("R8 full width load", 1'b1, 1'b0, 1'b0, 8'h81);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule